// File: doc/BRIEF.md
# Serial Coefficient Register Access Port

This block is a synchronous serial slave that lets an external host read and write a 256-byte file of camera coefficient registers. The host drives a serial clock, a serial data line and an enable strobe. The block returns read data on a serial output line. All four host lines are brought into the system clock domain through synchronizers, and their edges are detected there. The register storage sits outside the block and is reached over a simple byte-wide bus. The storage is expected to return read data one system clock after the read strobe.

A static mode pin chooses between two frame layouts. The narrow layout carries an 8-bit address and one data byte. The wide layout carries a 6-bit address and a 16-bit word, and that word maps onto a pair of adjacent byte registers. Write frames take effect only when the enable strobe rises. At that edge the frame is committed if its bit count is exactly right, and discarded otherwise. Read frames fetch the addressed bytes as soon as the address has arrived, and shift them back during the data phase of the same frame.

Timing assumption: each ser_clk phase lasts at least 8 system clocks.

Top module: `coef_serial_port`

## Requirements
- R1: A frame is sent MSB first on ser_clk rising edges as a direction flag (0 = write, 1 = read), then the address, then the data, and ser_en is held low while the frame is shifted.
- R2: With mode_wide low a frame is 17 bits (flag, 8-bit address, 8-bit data), and a write frame produces one bus_we cycle carrying that address and data byte.
- R3: With mode_wide high a frame is 23 bits (flag, 6-bit address A, 16-bit data), and a write frame produces two consecutive bus_we cycles: byte address 2A with data bits 7:0 first, then 2A+1 with data bits 15:8.
- R4: A write frame never drives bus_we before ser_en rises; bus_we is issued after that rising edge.
- R5: A frame whose bit count, when ser_en rises, is not exactly the frame length of the current mode (shorter or longer) causes no bus write. The bit counter is cleared on every ser_en rising edge, so the next frame is decoded normally.
- R6: In a narrow read frame, one bus_re cycle is issued at the address once the last address bit is in. The returned byte then appears on ser_dout MSB first: each data bit is valid before the ser_clk rising edge of its own data-bit position and changes only after a ser_clk falling edge.
- R7: In a wide read frame, bus_re is issued at byte address 2A+1 and then at 2A on the next cycle. ser_dout returns 16 bits, the high byte (from 2A+1) first, MSB first.
- R8: A read frame never asserts bus_we, and bus_we and bus_re are never high together.
- R9: When a ser_clk rising edge and a ser_en rising edge are seen in the same system cycle, the clock edge's bit is dropped. The commit is judged on the bits received before it.
- R10: After reset, ser_dout, bus_we and bus_re are low and the bit counter is empty.
- R11: ser_dout is low whenever no read data is pending: after reset, after any ser_en rising edge, and throughout a write frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Host serial clock, bits sampled on its rising edge |
| ser_en | input | 1 | Host enable strobe, rising edge commits a frame |
| ser_din | input | 1 | Host serial data in |
| mode_wide | input | 1 | Static frame layout select: 1 = 6-bit address/16-bit data, 0 = 8-bit address/8-bit data |
| ser_dout | output | 1 | Serial read data to host |
| bus_addr | output | 8 | Register byte address |
| bus_wdata | output | 8 | Register write byte |
| bus_we | output | 1 | Register write strobe, one byte per cycle |
| bus_re | output | 1 | Register read strobe |
| bus_rdata | input | 8 | Register read byte, valid the cycle after bus_re |

## Verification
The two functions that can fall in the same system cycle are sampling a serial bit and committing the frame on the enable edge. A host can raise ser_clk and ser_en together. The bench provokes this by shifting a complete narrow frame and then raising both lines, with ser_din high, at the same instant. The result is judged at the register bus: the commit must go through with the data of the first 17 bits, because counting the dropped bit would make the frame 18 bits and discard it. A following read frame must return that byte, which shows the counter was cleared.

// File: rtl/coef_port_pkg.sv
// Package: shared constants and state type for the serial coefficient port.
// Assumes the frame layouts fixed by the host protocol (flag, address, data).
package coef_port_pkg;

    localparam int BYTE_W     = 8;
    localparam int FLAG_W     = 1;
    localparam int NARROW_AW  = 8;
    localparam int NARROW_DW  = 8;
    localparam int WIDE_AW    = 6;
    localparam int WIDE_DW    = 16;
    localparam int BUS_AW     = NARROW_AW;
    localparam int NARROW_LEN = FLAG_W + NARROW_AW + NARROW_DW;
    localparam int WIDE_LEN   = FLAG_W + WIDE_AW + WIDE_DW;
    localparam int MAX_LEN    = (WIDE_LEN > NARROW_LEN) ? WIDE_LEN : NARROW_LEN;
    localparam int CNT_W      = $clog2(MAX_LEN + 2);
    localparam int OUT_W      = (WIDE_DW > NARROW_DW) ? WIDE_DW : NARROW_DW;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_WR_LO,
        SQ_WR_HI,
        SQ_RD_FIRST,
        SQ_RD_SECOND,
        SQ_CAPTURE
    } seq_state_t;

endpackage

// File: rtl/coef_sync.sv
// Module: multi-stage synchronizer for asynchronous host lines.
// Assumes each input is stable for several system clocks between changes.
module coef_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] lvl
);
    logic [STAGES-1:0][W-1:0] pipe;

    // Shift the raw inputs through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-2:0], async_in};
    end

    assign lvl = pipe[STAGES-1];
endmodule

// File: rtl/coef_edge_det.sv
// Module: per-bit rising and falling edge detector on synchronized levels.
// Assumes inputs are already in the clk domain.
module coef_edge_det #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev;

    // Remember last cycle's level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= lvl;
    end

    for (genvar g = 0; g < W; g++) begin : g_bit
        assign rise[g] = lvl[g] & ~prev[g];
        assign fall[g] = ~lvl[g] & prev[g];
    end
endmodule

// File: rtl/coef_frame_rx.sv
// Module: counts and shifts incoming serial bits, decodes read requests at the
// end of the address phase and write requests on the enable rising edge.
// Assumes mode_wide is static while a frame is in flight.
module coef_frame_rx
    import coef_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_rise,
    input  logic              en_lvl,
    input  logic              din,
    input  logic              wide,
    output logic              en_rise,
    output logic [CNT_W-1:0]  cnt,
    output logic              rd_req,
    output logic              wr_req,
    output logic [BUS_AW-1:0] req_addr,
    output logic [OUT_W-1:0]  wr_data
);
    logic               en_prev;
    logic [MAX_LEN-1:0] shreg;
    logic [CNT_W-1:0]   flen;
    logic [CNT_W-1:0]   alen;
    logic               addr_last;
    logic               rd_flag;
    logic [BUS_AW-1:0]  rd_addr;
    logic               cm_flag;
    logic [BUS_AW-1:0]  cm_addr;
    logic [OUT_W-1:0]   cm_data;
    logic               frame_full;

    assign flen = wide ? CNT_W'(WIDE_LEN) : CNT_W'(NARROW_LEN);
    assign alen = wide ? CNT_W'(WIDE_AW)  : CNT_W'(NARROW_AW);

    // Track the enable level to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) en_prev <= 1'b0;
        else        en_prev <= en_lvl;
    end
    assign en_rise = en_lvl & ~en_prev;

    // Shift bits in and count them; the enable edge wins over a bit edge (R9).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            shreg <= '0;
        end else if (en_rise) begin
            cnt <= '0;
        end else if (bit_rise) begin
            shreg <= {shreg[MAX_LEN-2:0], din};
            if (cnt != '1) cnt <= cnt + 1'b1;
        end
    end

    // Address-phase decode: incoming bit is the last address bit.
    assign addr_last = bit_rise && !en_rise && (cnt == alen);
    assign rd_flag   = wide ? shreg[WIDE_AW-1] : shreg[NARROW_AW-1];
    assign rd_addr   = wide ? {{(BUS_AW-WIDE_AW){1'b0}}, shreg[WIDE_AW-2:0], din}
                            : {shreg[NARROW_AW-2:0], din};

    // Commit decode at the enable edge from the completed frame.
    assign frame_full = (cnt == flen);
    assign cm_flag = wide ? shreg[WIDE_LEN-1] : shreg[NARROW_LEN-1];
    assign cm_addr = wide ? {{(BUS_AW-WIDE_AW){1'b0}}, shreg[WIDE_DW +: WIDE_AW]}
                          : shreg[NARROW_DW +: NARROW_AW];
    assign cm_data = wide ? shreg[WIDE_DW-1:0]
                          : {{(OUT_W-NARROW_DW){1'b0}}, shreg[NARROW_DW-1:0]};

    // Register read and write requests toward the bus sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_req   <= 1'b0;
            wr_req   <= 1'b0;
            req_addr <= '0;
            wr_data  <= '0;
        end else begin
            rd_req <= addr_last && rd_flag;
            wr_req <= en_rise && frame_full && !cm_flag;
            if (addr_last && rd_flag) begin
                req_addr <= rd_addr;
            end else if (en_rise && frame_full && !cm_flag) begin
                req_addr <= cm_addr;
                wr_data  <= cm_data;
            end
        end
    end

    AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        en_rise |=> (cnt == '0));  // R5
    AST_WRITE_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> ($past(en_rise) && ($past(cnt) == $past(flen))));  // R5
    AST_BIT_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_rise && !en_rise && (cnt < flen)) |=> (cnt == $past(cnt) + 1'b1));  // R1
    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req));  // R8
endmodule

// File: rtl/coef_bus_seq.sv
// Module: turns decoded requests into byte-wide register bus cycles and
// gathers read bytes for the serial return path.
// Assumes storage returns bus_rdata one cycle after bus_re, and that requests
// arrive only while idle (guaranteed by serial timing).
module coef_bus_seq
    import coef_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic              rd_req,
    input  logic              wide,
    input  logic [BUS_AW-1:0] req_addr,
    input  logic [OUT_W-1:0]  wr_data,
    input  logic [BYTE_W-1:0] bus_rdata,
    output logic [BUS_AW-1:0] bus_addr,
    output logic [BYTE_W-1:0] bus_wdata,
    output logic              bus_we,
    output logic              bus_re,
    output logic              load,
    output logic [OUT_W-1:0]  load_data
);
    seq_state_t        state, state_nx;
    logic [BUS_AW-1:0] a_q;
    logic [OUT_W-1:0]  d_q;
    logic              wide_q;
    logic [BYTE_W-1:0] hi_q;

    // Choose the next bus step from the current step and new requests.
    always_comb begin
        state_nx = state;
        case (state)
            SQ_IDLE:      if (wr_req) state_nx = SQ_WR_LO;
                          else if (rd_req) state_nx = SQ_RD_FIRST;
            SQ_WR_LO:     state_nx = wide_q ? SQ_WR_HI : SQ_IDLE;
            SQ_WR_HI:     state_nx = SQ_IDLE;
            SQ_RD_FIRST:  state_nx = wide_q ? SQ_RD_SECOND : SQ_CAPTURE;
            SQ_RD_SECOND: state_nx = SQ_CAPTURE;
            SQ_CAPTURE:   state_nx = SQ_IDLE;
            default:      state_nx = SQ_IDLE;
        endcase
    end

    // Advance the step and latch request fields and the first read byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SQ_IDLE;
            a_q    <= '0;
            d_q    <= '0;
            wide_q <= 1'b0;
            hi_q   <= '0;
        end else begin
            state <= state_nx;
            if (state == SQ_IDLE && (wr_req || rd_req)) begin
                a_q    <= req_addr;
                d_q    <= wr_data;
                wide_q <= wide;
            end
            if (state == SQ_RD_SECOND) hi_q <= bus_rdata;
        end
    end

    // Drive the register bus for the current step.
    always_comb begin
        bus_we    = 1'b0;
        bus_re    = 1'b0;
        bus_addr  = a_q;
        bus_wdata = d_q[BYTE_W-1:0];
        load      = 1'b0;
        load_data = wide_q ? {hi_q, bus_rdata}
                           : {bus_rdata, {(OUT_W-BYTE_W){1'b0}}};
        case (state)
            SQ_WR_LO: begin
                bus_we   = 1'b1;
                bus_addr = wide_q ? {a_q[BUS_AW-2:0], 1'b0} : a_q;
            end
            SQ_WR_HI: begin
                bus_we    = 1'b1;
                bus_addr  = {a_q[BUS_AW-2:0], 1'b1};
                bus_wdata = d_q[OUT_W-1 -: BYTE_W];
            end
            SQ_RD_FIRST: begin
                bus_re   = 1'b1;
                bus_addr = wide_q ? {a_q[BUS_AW-2:0], 1'b1} : a_q;
            end
            SQ_RD_SECOND: begin
                bus_re   = 1'b1;
                bus_addr = {a_q[BUS_AW-2:0], 1'b0};
            end
            SQ_CAPTURE: load = 1'b1;
            default: ;
        endcase
    end

    AST_WE_RE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_re));  // R8
    AST_WIDE_WRITE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && wide_q && !bus_addr[0]) |=> (bus_we && bus_addr == $past(bus_addr) + 1'b1));  // R3
    AST_NARROW_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && !wide_q) |=> !bus_re);  // R6
    AST_WIDE_READ_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && wide_q && bus_addr[0]) |=> (bus_re && bus_addr == $past(bus_addr) - 1'b1));  // R7
endmodule

// File: rtl/coef_dout_tx.sv
// Module: serial return shifter; presents the MSB after load and advances one
// bit on each ser_clk falling edge that follows a data-phase rising edge.
// Assumes the load lands before the falling edge after the last address bit.
module coef_dout_tx
    import coef_port_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_rise,
    input  logic             bit_fall,
    input  logic             en_rise,
    input  logic             wide,
    input  logic [CNT_W-1:0] cnt,
    input  logic             load,
    input  logic [OUT_W-1:0] load_data,
    output logic             ser_dout
);
    logic [OUT_W-1:0] sr;
    logic             pend;
    logic [CNT_W-1:0] flen;
    logic [CNT_W-1:0] dstart;
    logic             data_edge;

    assign flen      = wide ? CNT_W'(WIDE_LEN) : CNT_W'(NARROW_LEN);
    assign dstart    = wide ? CNT_W'(FLAG_W + WIDE_AW) : CNT_W'(FLAG_W + NARROW_AW);
    assign data_edge = bit_rise && !en_rise && (cnt >= dstart) && (cnt < flen);

    // Load, clear or shift the return register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr   <= '0;
            pend <= 1'b0;
        end else if (en_rise) begin
            sr   <= '0;
            pend <= 1'b0;
        end else if (load) begin
            sr   <= load_data;
            pend <= 1'b0;
        end else if (bit_fall && pend) begin
            sr   <= {sr[OUT_W-2:0], 1'b0};
            pend <= 1'b0;
        end else if (data_edge) begin
            pend <= 1'b1;
        end
    end

    assign ser_dout = sr[OUT_W-1];

    AST_DOUT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        en_rise |=> !ser_dout);  // R11
    AST_DOUT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_fall && !load && !en_rise) |=> $stable(ser_dout));  // R6
endmodule

// File: rtl/coef_serial_port.sv
// Module: top of the serial coefficient register port. Synchronizes host
// lines, decodes frames and drives the byte-wide register bus.
// Assumes each ser_clk phase lasts at least 8 clk cycles.
module coef_serial_port
    import coef_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_en,
    input  logic              ser_din,
    input  logic              mode_wide,
    output logic              ser_dout,
    output logic [BUS_AW-1:0] bus_addr,
    output logic [BYTE_W-1:0] bus_wdata,
    output logic              bus_we,
    output logic              bus_re,
    input  logic [BYTE_W-1:0] bus_rdata
);
    localparam int LINES = 3;

    logic [LINES-1:0]  lvl;
    logic              bit_rise, bit_fall, en_rise;
    logic [CNT_W-1:0]  cnt;
    logic              rd_req, wr_req, load;
    logic [BUS_AW-1:0] req_addr;
    logic [OUT_W-1:0]  wr_data, load_data;

    coef_sync #(.W(LINES), .STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n),
        .async_in({ser_din, ser_en, ser_clk}), .lvl(lvl)
    );

    coef_edge_det #(.W(1)) i_clk_edge (
        .clk(clk), .rst_n(rst_n), .lvl(lvl[0]),
        .rise(bit_rise), .fall(bit_fall)
    );

    coef_frame_rx i_rx (
        .clk(clk), .rst_n(rst_n), .bit_rise(bit_rise), .en_lvl(lvl[1]),
        .din(lvl[2]), .wide(mode_wide), .en_rise(en_rise), .cnt(cnt),
        .rd_req(rd_req), .wr_req(wr_req), .req_addr(req_addr), .wr_data(wr_data)
    );

    coef_bus_seq i_seq (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_req(rd_req),
        .wide(mode_wide), .req_addr(req_addr), .wr_data(wr_data),
        .bus_rdata(bus_rdata), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .load(load), .load_data(load_data)
    );

    coef_dout_tx i_tx (
        .clk(clk), .rst_n(rst_n), .bit_rise(bit_rise), .bit_fall(bit_fall),
        .en_rise(en_rise), .wide(mode_wide), .cnt(cnt), .load(load),
        .load_data(load_data), .ser_dout(ser_dout)
    );

    AST_WRITE_AFTER_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_we) |-> $past(wr_req));  // R4
endmodule

// File: tb/test_coef_serial_port.sv
module test_coef_serial_port;
    localparam int HALF = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_en = 1'b0, ser_din = 1'b0, mode_wide = 1'b0;
    logic ser_dout, bus_we, bus_re;
    logic [7:0] bus_addr, bus_wdata, bus_rdata;

    int errors = 0;
    int checks = 0;

    logic [7:0] mem [256];
    logic [7:0] rdata_q = 8'h00;
    logic [7:0] we_a [4];
    logic [7:0] we_d [4];
    logic [7:0] re_a [4];
    int we_n = 0;
    int re_n = 0;

    // {wide, addr, data}
    localparam logic [24:0] VEC [6] = '{
        {1'b0, 8'h00, 16'h005A},
        {1'b0, 8'hFF, 16'h00C3},
        {1'b0, 8'h81, 16'h0001},
        {1'b1, 8'h00, 16'hA55A},
        {1'b1, 8'h3F, 16'h8001},
        {1'b1, 8'h15, 16'h7E18}
    };

    always #4 clk = ~clk;

    coef_serial_port i_coef_serial_port (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_en(ser_en),
        .ser_din(ser_din), .mode_wide(mode_wide), .ser_dout(ser_dout),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_re(bus_re), .bus_rdata(bus_rdata)
    );

    // Register storage model: synchronous write, registered read.
    initial for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    always @(posedge clk) begin
        if (bus_we) mem[bus_addr] <= bus_wdata;
        if (bus_re) rdata_q <= mem[bus_addr];
    end
    assign bus_rdata = rdata_q;

    // Bus monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && bus_we) begin
            if (we_n < 4) begin we_a[we_n] = bus_addr; we_d[we_n] = bus_wdata; end
            we_n = we_n + 1;
        end
        if (rst_n && bus_re) begin
            if (re_n < 4) re_a[re_n] = bus_addr;
            re_n = re_n + 1;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Shift one frame (first nbits of it, zeros beyond), then raise enable.
    task automatic send_frame(input logic wide_i, input logic rw,
                              input logic [7:0] addr, input logic [15:0] data,
                              input int nbits, input logic coincide,
                              output logic [15:0] got, output int we_before,
                              output int dout_ones);
        int flen = wide_i ? 23 : 17;
        int alen = wide_i ? 6 : 8;
        logic [22:0] fr;
        fr = wide_i ? {rw, addr[5:0], data} : {6'b0, rw, addr, data[7:0]};
        got = 16'h0;
        dout_ones = 0;
        @(negedge clk);
        mode_wide = wide_i;
        repeat (HALF) @(negedge clk);
        we_n = 0;
        re_n = 0;
        for (int k = 0; k < nbits; k++) begin
            ser_din = (k < flen) ? fr[flen-1-k] : 1'b0;
            repeat (HALF) @(negedge clk);
            if (k >= 1 + alen && k < flen) got = {got[14:0], ser_dout};
            if (ser_dout) dout_ones++;
            ser_clk = 1'b1;
            repeat (HALF) @(negedge clk);
            ser_clk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        we_before = we_n;
        if (coincide) begin
            ser_din = 1'b1;
            ser_clk = 1'b1;
        end
        ser_en = 1'b1;
        repeat (HALF) @(negedge clk);
        ser_clk = 1'b0;
        ser_en = 1'b0;
        repeat (2 * HALF) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R1 watchdog expired: actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [15:0] got;
        int wb, ones;
        repeat (5) @(negedge clk);
        chk("R10", "dout after reset", 32'(ser_dout), 0);
        chk("R10", "we after reset", 32'(bus_we), 0);
        chk("R10", "re after reset", 32'(bus_re), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        for (int v = 0; v < 6; v++) begin
            logic w;
            logic [7:0] a;
            logic [15:0] d;
            {w, a, d} = VEC[v];
            send_frame(w, 1'b0, a, d, w ? 23 : 17, 1'b0, got, wb, ones);
            chk("R4", "we before enable", 32'(wb), 0);
            chk("R11", "dout ones in write frame", 32'(ones), 0);
            if (!w) begin
                chk("R2", "write count", 32'(we_n), 1);
                chk("R2", "write addr", 32'(we_a[0]), 32'(a));
                chk("R2", "write data", 32'(we_d[0]), 32'(d[7:0]));
            end else begin
                chk("R3", "write count", 32'(we_n), 2);
                chk("R3", "low addr", 32'(we_a[0]), 32'({1'b0, a[5:0], 1'b0}));
                chk("R3", "low data", 32'(we_d[0]), 32'(d[7:0]));
                chk("R3", "high addr", 32'(we_a[1]), 32'({1'b0, a[5:0], 1'b1}));
                chk("R3", "high data", 32'(we_d[1]), 32'(d[15:8]));
            end
            send_frame(w, 1'b1, a, 16'h0, w ? 23 : 17, 1'b0, got, wb, ones);
            chk("R8", "no write in read frame", 32'(we_n), 0);
            if (!w) begin
                chk("R6", "read count", 32'(re_n), 1);
                chk("R6", "read addr", 32'(re_a[0]), 32'(a));
                chk("R6", "read data", 32'(got[7:0]), 32'(d[7:0]));
            end else begin
                chk("R7", "read count", 32'(re_n), 2);
                chk("R7", "first read addr", 32'(re_a[0]), 32'({1'b0, a[5:0], 1'b1}));
                chk("R7", "second read addr", 32'(re_a[1]), 32'({1'b0, a[5:0], 1'b0}));
                chk("R7", "read data", 32'(got), 32'(d));
            end
            chk("R11", "dout after enable", 32'(ser_dout), 0);
        end

        // R5: short and long frames are discarded; next frame still decodes.
        send_frame(1'b0, 1'b0, 8'h40, 16'h0011, 17, 1'b0, got, wb, ones);
        chk("R2", "seed write", 32'(we_n), 1);
        send_frame(1'b0, 1'b0, 8'h40, 16'h0077, 16, 1'b0, got, wb, ones);
        chk("R5", "short frame writes", 32'(we_n), 0);
        send_frame(1'b0, 1'b0, 8'h40, 16'h0099, 18, 1'b0, got, wb, ones);
        chk("R5", "long frame writes", 32'(we_n), 0);
        send_frame(1'b1, 1'b0, 8'h20, 16'hBEEF, 22, 1'b0, got, wb, ones);
        chk("R5", "short wide frame writes", 32'(we_n), 0);
        send_frame(1'b0, 1'b1, 8'h40, 16'h0, 17, 1'b0, got, wb, ones);
        chk("R5", "value kept after bad frames", 32'(got[7:0]), 32'h11);

        // R9: clock and enable edges together; the bit is dropped.
        send_frame(1'b0, 1'b0, 8'h40, 16'h003C, 17, 1'b1, got, wb, ones);
        chk("R9", "coincident commit count", 32'(we_n), 1);
        chk("R9", "coincident commit data", 32'(we_d[0]), 32'h3C);
        send_frame(1'b0, 1'b1, 8'h40, 16'h0, 17, 1'b0, got, wb, ones);
        chk("R9", "frame after coincident edge", 32'(got[7:0]), 32'h3C);
        chk("R1", "read after coincident edge addr", 32'(re_a[0]), 32'h40);

        finish_run();
    end
endmodule